// File: doc/BRIEF.md
# Dual-Clock FIFO with Fill Flags and Lane Parity

This block is a first-in first-out buffer of 1024 words of 36 bits. It sits between a producer and a consumer that run on separate clocks. The write port and the read port each have their own free-running clock and an active-low enable. The two clocks may be the same net or fully independent. Each pointer reaches the other clock domain as a Gray-coded value through a two-stage synchroniser. Emptiness is decided in the read domain. Fullness and the quarter, half and three-quarter fill levels are decided in the write domain.

Each word is treated as four 9-bit lanes. The top bit of each lane is that lane's parity bit. Software-facing configuration pins select whether parity is generated on write, whether it is checked on read, and whether the sense is even or odd. A write while full, or a read while empty, is refused and latches a sticky error. A parity mismatch on read latches a separate sticky parity error. The read data bus can be released to high impedance through an active-low output enable. An active-low master reset returns the whole block to empty.

Top module: `dcf_fifo`

## Requirements
- R1: Every accepted word is delivered exactly once, in write order. This holds with asynchronous clocks and with reads and writes in the same cycles.
- R2: A rising edge of `wclk` with `wen_n` low and `full` low stores `wdata` (after parity generation, see R10) as the next word.
- R3: A rising edge of `rclk` with `ren_n` low and `empty` low loads the oldest word into the read register, and it drives `rdata` after that edge. With `ren_n` high, `rdata` holds its value.
- R4: With `oe_n` high, `rdata` is high impedance. With `oe_n` low, `rdata` drives the read register, which is zero after reset.
- R5: `mrst_n` is a synchronous reset held low over at least three rising edges of each clock. It empties the FIFO and clears every flag, the read register, `err` and `par_err`, and it sets `empty`.
- R6: `empty` is 1 exactly when the read domain sees no unread word. After a write into an empty FIFO, `empty` falls within three rising edges of `rclk`.
- R7: `full` is 1 when the write-domain occupancy equals 1024. A write attempted while `full` is 1 stores nothing and leaves the stored words unchanged.
- R8: `quarter`, `half` and `three_q` are 1 when the write-domain occupancy (written words minus the synchronised read count) is at least 256, 512 and 768 respectively.
- R9: A write attempted while full, or a read attempted while empty, sets `err`, which stays 1 until master reset. A read attempted while empty leaves `rdata` unchanged.
- R10: Lane k occupies bits [9k+8:9k], and bit 9k+8 is its parity bit over bits [9k+7:9k]. With `par_odd` at 0 the nine bits carry an even number of ones; with `par_odd` at 1, an odd number. With `par_gen` at 1, the four parity bits are replaced on write. With `par_gen` at 0, the word is stored as given.
- R11: With `par_chk` at 1, reading a word in which any lane violates the selected sense sets `par_err` after that read edge. It stays 1 until master reset. Words that match do not set it, and with `par_chk` at 0 it is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | 36 | Write data |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable for `rdata`, active low |
| rdata | output | 36 | Read data, high impedance when `oe_n` is high |
| par_gen | input | 1 | Replace lane parity bits on write |
| par_chk | input | 1 | Check lane parity on read |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd |
| empty | output | 1 | No unread word (read domain) |
| full | output | 1 | 1024 words held (write domain) |
| quarter | output | 1 | At least 256 words held (write domain) |
| half | output | 1 | At least 512 words held (write domain) |
| three_q | output | 1 | At least 768 words held (write domain) |
| err | output | 1 | Sticky write-while-full or read-while-empty |
| par_err | output | 1 | Sticky parity mismatch on read |

## Verification
The bench fills the buffer word by word from empty with reads idle. At each count it compares the fill flags, so a threshold off by one shows up at 255, 511, 767 or 1023 words. It then pushes one write past full and drains all 1024 words. A design that let the extra word in, or wrapped its pointer, returns a wrong or shifted word sequence and would also miss the sticky `err`. A read against an empty buffer must leave `rdata` alone and raise `err`. Deliberately corrupted lane parity must raise `par_err` only when checking is on. A long run with random enables on two unrelated clocks catches lost, duplicated or reordered words from a broken Gray crossing or full/empty compare.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int LANE_W = 9;
    localparam int PAY_W  = LANE_W - 1;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_sense_e;

    typedef struct packed {
        logic full;
        logic three_q;
        logic half;
        logic quarter;
    } fill_t;

    // parity bit that brings a lane to the selected sense
    function automatic logic lane_par(input logic [PAY_W-1:0] pay, input par_sense_e sense);
        return (^pay) ^ sense;
    endfunction

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wword;
        end
    end

    assign rword = store[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              par_gen,
    input  logic              par_odd,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wword,
    output logic [ADDR_W:0]   wgray,
    output fill_t             fill,
    output logic              ovf_err
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = DATA_W / LANE_W;
    localparam int LEFT  = DATA_W - LANES * LANE_W;
    localparam logic [PTR_W-1:0] LVL_FULL = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LVL_Q1   = PTR_W'(DEPTH / 4);
    localparam logic [PTR_W-1:0] LVL_Q2   = PTR_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LVL_Q3   = PTR_W'((3 * DEPTH) / 4);

    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nx;
    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] occ;
    par_sense_e       sense;

    assign sense   = par_sense_e'(par_odd);
    assign rbin_s  = PTR_W'(from_gray(32'(rgray_s)));
    assign occ     = wbin - rbin_s;
    assign wbin_nx = wbin + PTR_W'(1);
    assign waddr   = wbin[ADDR_W-1:0];

    always_comb begin
        fill.full    = (occ == LVL_FULL);
        fill.three_q = (occ >= LVL_Q3);
        fill.half    = (occ >= LVL_Q2);
        fill.quarter = (occ >= LVL_Q1);
    end

    assign we = !wen_n && !fill.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin    <= '0;
            wgray   <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= PTR_W'(to_gray(32'(wbin_nx)));
            end
            if (!wen_n && fill.full) begin
                ovf_err <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PAY_W-1:0] pay;
        assign pay = wdata[g*LANE_W +: PAY_W];
        assign wword[g*LANE_W +: PAY_W] = pay;
        assign wword[g*LANE_W + PAY_W]  = par_gen ? lane_par(pay, sense)
                                                  : wdata[g*LANE_W + PAY_W];
    end

    if (LEFT > 0) begin : g_tail
        assign wword[DATA_W-1 -: LEFT] = wdata[DATA_W-1 -: LEFT];
    end

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_n,
    input  logic              par_chk,
    input  logic              par_odd,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] rword,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_q,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic              udf_err,
    output logic              par_err
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int LANES = DATA_W / LANE_W;

    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] rbin_nx;
    logic [PTR_W-1:0] wbin_s;
    logic [LANES-1:0] lane_bad;
    logic             re;
    par_sense_e       sense;

    assign sense   = par_sense_e'(par_odd);
    assign wbin_s  = PTR_W'(from_gray(32'(wgray_s)));
    assign empty   = (rbin == wbin_s);
    assign re      = !ren_n && !empty;
    assign rbin_nx = rbin + PTR_W'(1);
    assign raddr   = rbin[ADDR_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = rword[g*LANE_W + PAY_W]
                           != lane_par(rword[g*LANE_W +: PAY_W], sense);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            rdata_q <= '0;
            udf_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            if (re) begin
                rbin    <= rbin_nx;
                rgray   <= PTR_W'(to_gray(32'(rbin_nx)));
                rdata_q <= rword;
                if (par_chk && (|lane_bad)) begin
                    par_err <= 1'b1;
                end
            end
            if (!ren_n && empty) begin
                udf_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ren_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    input  logic              par_gen,
    input  logic              par_chk,
    input  logic              par_odd,
    output logic              empty,
    output logic              full,
    output logic              quarter,
    output logic              half,
    output logic              three_q,
    output logic              err,
    output logic              par_err
);

    localparam int PTR_W = ADDR_W + 1;

    logic              rst;
    logic              w_en;
    logic [ADDR_W-1:0] w_addr;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] w_word;
    logic [DATA_W-1:0] r_word;
    logic [DATA_W-1:0] rdata_q;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_s;
    logic [PTR_W-1:0]  rgray_s;
    logic              ovf_err;
    logic              udf_err;
    fill_t             fill;

    assign rst = !mrst_n;

    dcf_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_wr (
        .clk     (wclk),
        .rst     (rst),
        .wen_n   (wen_n),
        .wdata   (wdata),
        .par_gen (par_gen),
        .par_odd (par_odd),
        .rgray_s (rgray_s),
        .we      (w_en),
        .waddr   (w_addr),
        .wword   (w_word),
        .wgray   (wgray),
        .fill    (fill),
        .ovf_err (ovf_err)
    );

    dcf_sync #(.W(PTR_W)) i_sync_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    dcf_sync #(.W(PTR_W)) i_sync_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wclk  (wclk),
        .we    (w_en),
        .waddr (w_addr),
        .wword (w_word),
        .raddr (r_addr),
        .rword (r_word)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .clk     (rclk),
        .rst     (rst),
        .ren_n   (ren_n),
        .par_chk (par_chk),
        .par_odd (par_odd),
        .wgray_s (wgray_s),
        .rword   (r_word),
        .raddr   (r_addr),
        .rdata_q (rdata_q),
        .rgray   (rgray),
        .empty   (empty),
        .udf_err (udf_err),
        .par_err (par_err)
    );

    assign full    = fill.full;
    assign three_q = fill.three_q;
    assign half    = fill.half;
    assign quarter = fill.quarter;
    assign err     = ovf_err | udf_err;
    assign rdata   = oe_n ? {DATA_W{1'bz}} : rdata_q;

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst_n,
    input logic              wen_n,
    input logic              ren_n,
    input logic              empty,
    input logic              full,
    input logic              quarter,
    input logic              half,
    input logic              three_q,
    input logic              err,
    input logic              par_err,
    input logic [ADDR_W-1:0] w_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] rdata_q
);

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!mrst_n)
        (full && !wen_n) |=> $stable(w_addr)); // R7

    AST_FULL_ABOVE_TQ: assert property (@(posedge wclk) disable iff (!mrst_n)
        full |-> three_q); // R8

    AST_FILL_ORDER: assert property (@(posedge wclk) disable iff (!mrst_n)
        (three_q |-> half) and (half |-> quarter)); // R8

    AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (!mrst_n)
        (empty && !ren_n) |=> ($stable(r_addr) && $stable(rdata_q))); // R9

    AST_READ_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n)
        ren_n |=> $stable(rdata_q)); // R3

    AST_ERR_STICKY: assert property (@(posedge wclk) disable iff (!mrst_n)
        err |=> err); // R9

    AST_PAR_STICKY: assert property (@(posedge rclk) disable iff (!mrst_n)
        par_err |=> par_err); // R11

endmodule

bind dcf_fifo dcf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .mrst_n  (mrst_n),
    .wen_n   (wen_n),
    .ren_n   (ren_n),
    .empty   (empty),
    .full    (full),
    .quarter (quarter),
    .half    (half),
    .three_q (three_q),
    .err     (err),
    .par_err (par_err),
    .w_addr  (w_addr),
    .r_addr  (r_addr),
    .rdata_q (rdata_q)
);

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        wen_n = 1'b1;
    logic [35:0] wdata = '0;
    logic        ren_n = 1'b1;
    logic        oe_n = 1'b0;
    tri1  [35:0] rdata_w;
    logic        par_gen = 1'b0;
    logic        par_chk = 1'b0;
    logic        par_odd = 1'b0;
    logic        empty, full, quarter, half, three_q, err, par_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [35:0] model[$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    dcf_fifo i_dcf_fifo (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wen_n(wen_n), .wdata(wdata),
        .ren_n(ren_n), .oe_n(oe_n), .rdata(rdata_w), .par_gen(par_gen),
        .par_chk(par_chk), .par_odd(par_odd), .empty(empty), .full(full),
        .quarter(quarter), .half(half), .three_q(three_q), .err(err), .par_err(par_err)
    );

    function automatic logic [35:0] gen_par(input logic [35:0] d, input logic odd);
        logic [35:0] r = d;
        for (int k = 0; k < 4; k++) r[9*k+8] = (^d[9*k +: 8]) ^ odd;
        return r;
    endfunction

    function automatic logic [35:0] rnd36();
        return {4'($urandom()), $urandom()};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        mrst_n = 1'b0;
        wen_n  = 1'b1;
        ren_n  = 1'b1;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        mrst_n = 1'b1;
        model.delete();
        repeat (2) @(negedge rclk);
    endtask

    task automatic wr_cycle(input logic en, input logic [35:0] d);
        logic f;
        @(negedge wclk);
        wen_n = !en;
        wdata = d;
        f = full;
        @(posedge wclk);
        if (en && !f) model.push_back(par_gen ? gen_par(d, par_odd) : d);
        #1 wen_n = 1'b1;
    endtask

    task automatic rd_cycle(input logic en, input string tag);
        logic e;
        logic [35:0] exp;
        @(negedge rclk);
        ren_n = !en;
        e = empty;
        @(posedge rclk);
        #1 ren_n = 1'b1;
        if (en && !e) begin
            if (model.size() == 0) begin
                chk({tag, " unexpected word"}, 64'(rdata_w), 64'hdead);
            end else begin
                exp = model.pop_front();
                chk(tag, 64'(rdata_w), 64'(exp));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [35:0] d;
        logic [35:0] held;
        int k;
        int guard;
        void'($urandom(32'd20240611));

        // reset state
        do_reset();
        chk("R5 empty after reset", 64'(empty), 1);
        chk("R5 flags after reset", 64'({full, three_q, half, quarter}), 0);
        chk("R5 errors after reset", 64'({err, par_err}), 0);
        chk("R4 rdata driven zero", 64'(rdata_w), 0);
        oe_n = 1'b1;
        #1 chk("R4 rdata released", 64'(rdata_w), 64'({36{1'b1}}));
        oe_n = 1'b0;

        // read while empty
        rd_cycle(1'b1, "R9 none");
        chk("R9 err on empty read", 64'(err), 1);
        chk("R9 rdata kept on empty read", 64'(rdata_w), 0);
        do_reset();
        chk("R5 err cleared by reset", 64'(err), 0);

        // empty latency and single word
        d = rnd36();
        wr_cycle(1'b1, d);
        k = 0;
        while (empty && k < 4) begin
            @(posedge rclk);
            #1 k++;
        end
        chk("R6 empty falls within three read edges", 64'(k <= 3 && !empty), 1);
        rd_cycle(1'b1, "R3 single word");
        chk("R6 empty after last word", 64'(empty), 1);
        held = rdata_w;
        repeat (3) rd_cycle(1'b0, "R3");
        chk("R3 rdata held while idle", 64'(rdata_w), 64'(held));

        // fill to the top, flags at every level
        do_reset();
        for (int n = 1; n <= 1024; n++) begin
            wr_cycle(1'b1, rnd36());
            chk("R8 fill flags", 64'({three_q, half, quarter}),
                64'({n >= 768, n >= 512, n >= 256}));
            chk("R7 full level", 64'(full), 64'(n == 1024));
        end
        chk("R2 words accepted", 64'(model.size()), 1024);
        chk("R9 no err before overflow", 64'(err), 0);
        wr_cycle(1'b1, 36'h0_1234_5678);
        chk("R9 err on overflow", 64'(err), 1);
        chk("R7 still full after refused write", 64'(full), 1);
        guard = 0;
        while (model.size() > 0 && guard < 3000) begin
            rd_cycle(1'b1, "R1 drain after overflow");
            guard++;
        end
        chk("R7 overflow word not stored", 64'(model.size()), 0);
        rd_cycle(1'b1, "R9 none");
        chk("R6 empty after drain", 64'(empty), 1);
        chk("R9 err stays set", 64'(err), 1);

        // parity generation, even then odd
        for (int s = 0; s < 2; s++) begin
            do_reset();
            par_gen = 1'b1;
            par_chk = 1'b1;
            par_odd = s[0];
            for (int n = 0; n < 8; n++) wr_cycle(1'b1, rnd36());
            guard = 0;
            while (model.size() > 0 && guard < 50) begin
                rd_cycle(1'b1, "R10 generated parity");
                guard++;
            end
            chk("R11 no error on generated parity", 64'(par_err), 0);
        end

        // parity checking of corrupted words
        do_reset();
        par_gen = 1'b0;
        par_chk = 1'b0;
        par_odd = 1'b0;
        d = gen_par(rnd36(), 1'b0);
        d[17] = ~d[17];
        wr_cycle(1'b1, d);
        repeat (4) @(posedge rclk);
        rd_cycle(1'b1, "R10 raw store");
        chk("R11 unchecked bad word ignored", 64'(par_err), 0);
        wr_cycle(1'b1, gen_par(rnd36(), 1'b0));
        repeat (4) @(posedge rclk);
        par_chk = 1'b1;
        rd_cycle(1'b1, "R10 raw store");
        chk("R11 good word no error", 64'(par_err), 0);
        wr_cycle(1'b1, d);
        repeat (4) @(posedge rclk);
        rd_cycle(1'b1, "R10 raw store");
        chk("R11 bad lane sets par_err", 64'(par_err), 1);
        wr_cycle(1'b1, gen_par(rnd36(), 1'b0));
        repeat (4) @(posedge rclk);
        rd_cycle(1'b1, "R10 raw store");
        chk("R11 par_err sticky", 64'(par_err), 1);

        // random traffic on unrelated clocks
        do_reset();
        par_gen = 1'b1;
        par_chk = 1'b1;
        par_odd = 1'b1;
        fork
            begin
                for (int n = 0; n < 3000; n++) begin
                    int pct;
                    pct = (n < 1500) ? 75 : 40;
                    wr_cycle($urandom_range(99) < pct, rnd36());
                end
            end
            begin
                for (int n = 0; n < 2600; n++) begin
                    int pct;
                    pct = (n < 1300) ? 45 : 90;
                    rd_cycle($urandom_range(99) < pct, "R1 random order");
                end
            end
        join
        guard = 0;
        while (model.size() > 0 && guard < 4000) begin
            rd_cycle(1'b1, "R1 final drain");
            guard++;
        end
        chk("R1 every word delivered", 64'(model.size()), 0);
        chk("R11 no parity error in random run", 64'(par_err), 0);

        finish_run();
    end

endmodule